// File: doc/BRIEF.md
# Programmable Bidirectional Pad Cell Group

This block is a row of identical pad-interface cells that share one group output enable. Each cell sits between a pad, modelled as separate pad input, pad output and pad driver-enable signals, and the core logic. A three-bit mode field per cell turns the cell into one of five kinds of pin:

- a plain combinational input;
- an input captured by a flop on the rising edge of the I/O clock;
- an input held by a latch that is open while the I/O clock is high;
- a driven output;
- a bidirectional pin whose driver is governed by the shared group enable.

A per-cell invert bit sets the polarity of the outgoing data. The capture path is never inverted.

The row is sixteen cells wide by default. All cells see the same I/O clock, the same active-low reset and the same group enable. The active-low reset clears both the capture flop and the capture latch at once, without waiting for a clock edge.

Top module: `pad_cell_group`

## Requirements
- R1: With mode code 000, `core_in` equals `pad_in` in the same cycle and `pad_oe` is 0.
- R2: With mode code 001, `core_in` takes the value `pad_in` had at the most recent rising edge of `clk_io`, and holds it between edges.
- R3: With mode code 010, `core_in` follows `pad_in` while `clk_io` is high and keeps the last value while `clk_io` is low.
- R4: With mode code 011, `pad_oe` is 1 whatever `grp_oe` is, and `pad_out` carries the cell's `core_out` bit (after polarity).
- R5: With mode code 100, `pad_oe` equals `grp_oe` and `core_in` equals `pad_in`, so the pad is read back while the driver is off.
- R6: A set `cfg_inv` bit makes `pad_out` the complement of `core_out`, and a clear bit passes it unchanged; `cfg_inv` never changes `core_in`.
- R7: While `rst_n` is 0, the capture flop and the capture latch are 0, so `core_in` reads 0 in modes 001 and 010; this takes effect without a clock edge.
- R8: Mode codes 101, 110 and 111 behave exactly like code 000.
- R9: `grp_oe` is common to all cells: it drives `pad_oe` of every cell in mode 100 and has no effect on `pad_oe` of cells in modes 000, 001, 010 or 101 to 111.
- R10: With mode code 011, `core_in` equals `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | I/O clock for the capture flop and the latch enable |
| rst_n | input | 1 | Active-low reset of the capture storage |
| grp_oe | input | 1 | Output enable shared by the whole group |
| cfg_mode | input | 3*NUM_CELLS | Mode code per cell; cell i uses bits [3i+2:3i] |
| cfg_inv | input | NUM_CELLS | Output polarity per cell (1 = invert) |
| core_out | input | NUM_CELLS | Outgoing data from the core, one bit per cell |
| core_in | output | NUM_CELLS | Incoming data to the core, one bit per cell |
| pad_in | input | NUM_CELLS | Level seen at each pad |
| pad_out | output | NUM_CELLS | Data driven toward each pad |
| pad_oe | output | NUM_CELLS | Driver enable for each pad |

## Verification
The bench checks the latch at both clock phases.

- **Latch phases.** Data is changed while the clock is high and then again while it is low. A latch with the wrong enable phase, or one built as a flop, shows the wrong value in one of the two checks.
- **Flop timing.** A registered-mode value is changed mid-cycle and read before the next edge. This exposes a flop that is transparent.
- **Mixed row.** Cells are set to different modes and unused codes, then the group enable is toggled. A decoder that lets the shared enable leak into input cells, or that treats an unused code as output, gives the wrong enable pattern.
- **Polarity and reset.** Inversion is checked on both the driven data and the captured data, which catches polarity applied to the wrong path. A reset pulsed in mid-run with no clock edge catches a synchronous clear.

// File: rtl/pad_cell_pkg.sv
package pad_cell_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      PCM_COMB  = 3'b000,
      PCM_REG   = 3'b001,
      PCM_LATCH = 3'b010,
      PCM_OUT   = 3'b011,
      PCM_BIDIR = 3'b100
   } pcm_mode_e;

   // Unused codes resolve to the combinational input.
   function automatic pcm_mode_e pcm_resolve(input logic [MODE_W-1:0] raw);
      pcm_mode_e m;
      case (raw)
         3'b001:  m = PCM_REG;
         3'b010:  m = PCM_LATCH;
         3'b011:  m = PCM_OUT;
         3'b100:  m = PCM_BIDIR;
         default: m = PCM_COMB;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/pad_capture.sv
module pad_capture #(
   parameter bit CLR_VAL = 1'b0
) (
   input  logic clk_io,
   input  logic rst_n,
   input  logic pad_in,
   output logic flop_q,
   output logic latch_q
);
   // Edge-triggered capture.
   always_ff @(posedge clk_io or negedge rst_n) begin
      if (!rst_n) flop_q <= CLR_VAL;
      else        flop_q <= pad_in;
   end

   // Level-sensitive capture: open while clk_io is high.
   always_latch begin
      if (!rst_n)      latch_q <= CLR_VAL;
      else if (clk_io) latch_q <= pad_in;
   end
endmodule

// File: rtl/pad_drive.sv
module pad_drive
   import pad_cell_pkg::*;
(
   input  pcm_mode_e mode,
   input  logic      inv,
   input  logic      core_out,
   input  logic      grp_oe,
   output logic      pad_out,
   output logic      pad_oe
);
   assign pad_out = core_out ^ inv;

   always_comb begin
      case (mode)
         PCM_OUT:   pad_oe = 1'b1;
         PCM_BIDIR: pad_oe = grp_oe;
         default:   pad_oe = 1'b0;
      endcase
   end
endmodule

// File: rtl/pad_cell.sv
module pad_cell
   import pad_cell_pkg::*;
#(
   parameter bit CLR_VAL = 1'b0
) (
   input  logic              clk_io,
   input  logic              rst_n,
   input  logic              grp_oe,
   input  logic [MODE_W-1:0] mode_raw,
   input  logic              inv,
   input  logic              core_out,
   output logic              core_in,
   input  logic              pad_in,
   output logic              pad_out,
   output logic              pad_oe
);
   pcm_mode_e mode;
   logic      flop_q;
   logic      latch_q;

   assign mode = pcm_resolve(mode_raw);

   pad_capture #(.CLR_VAL(CLR_VAL)) i_cap (
      .clk_io  (clk_io),
      .rst_n   (rst_n),
      .pad_in  (pad_in),
      .flop_q  (flop_q),
      .latch_q (latch_q)
   );

   pad_drive i_drv (
      .mode     (mode),
      .inv      (inv),
      .core_out (core_out),
      .grp_oe   (grp_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   // Path toward the core: never inverted.
   always_comb begin
      case (mode)
         PCM_REG:   core_in = flop_q;
         PCM_LATCH: core_in = latch_q;
         default:   core_in = pad_in;
      endcase
   end

   // R1 / R8: unregistered paths reflect the pad directly.
   p_comb_path_r1: assert property (@(posedge clk_io) disable iff (!rst_n)
      (mode == PCM_COMB) |-> (core_in == pad_in && !pad_oe));

   // R2: registered mode shows the value sampled at the previous edge.
   p_reg_capture_r2: assert property (@(posedge clk_io) disable iff (!rst_n)
      (mode == PCM_REG && $past(rst_n)) |-> core_in == $past(pad_in));

   // R3: at the falling edge the latch is still open.
   p_latch_open_r3: assert property (@(negedge clk_io) disable iff (!rst_n)
      (mode == PCM_LATCH) |-> core_in == pad_in);

   // R4: output mode always drives.
   p_out_drives_r4: assert property (@(posedge clk_io) disable iff (!rst_n)
      (mode == PCM_OUT) |-> pad_oe);

   // R5 / R9: bidirectional driver follows the shared enable.
   p_bidir_oe_r5: assert property (@(posedge clk_io) disable iff (!rst_n)
      (mode == PCM_BIDIR) |-> (pad_oe == grp_oe && core_in == pad_in));

   // R6: driven data carries the selected polarity.
   p_polarity_r6: assert property (@(posedge clk_io) disable iff (!rst_n)
      pad_oe |-> ((pad_out ^ inv) == core_out));

   // R9: input-type modes never enable the driver.
   p_input_no_drive_r9: assert property (@(posedge clk_io) disable iff (!rst_n)
      (mode != PCM_OUT && mode != PCM_BIDIR) |-> !pad_oe);
endmodule

// File: rtl/pad_cell_group.sv
module pad_cell_group
   import pad_cell_pkg::*;
#(
   parameter int NUM_CELLS = 16,
   parameter bit CLR_VAL   = 1'b0
) (
   input  logic                        clk_io,
   input  logic                        rst_n,
   input  logic                        grp_oe,
   input  logic [NUM_CELLS*MODE_W-1:0] cfg_mode,
   input  logic [NUM_CELLS-1:0]        cfg_inv,
   input  logic [NUM_CELLS-1:0]        core_out,
   output logic [NUM_CELLS-1:0]        core_in,
   input  logic [NUM_CELLS-1:0]        pad_in,
   output logic [NUM_CELLS-1:0]        pad_out,
   output logic [NUM_CELLS-1:0]        pad_oe
);
   localparam int CFG_W = NUM_CELLS * MODE_W;

   if (NUM_CELLS < 1) begin : g_bad_count
      $error("pad_cell_group: NUM_CELLS must be at least 1");
   end
   if (CFG_W != $bits(cfg_mode)) begin : g_bad_cfg
      $error("pad_cell_group: mode field width mismatch");
   end

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      pad_cell #(.CLR_VAL(CLR_VAL)) i_cell (
         .clk_io   (clk_io),
         .rst_n    (rst_n),
         .grp_oe   (grp_oe),
         .mode_raw (cfg_mode[i*MODE_W +: MODE_W]),
         .inv      (cfg_inv[i]),
         .core_out (core_out[i]),
         .core_in  (core_in[i]),
         .pad_in   (pad_in[i]),
         .pad_out  (pad_out[i]),
         .pad_oe   (pad_oe[i])
      );
   end
endmodule

// File: tb/test_pad_cell_group.sv
module test_pad_cell_group;
   localparam int NC = 16;

   logic          clk_io = 1'b0;
   logic          rst_n  = 1'b0;
   logic          grp_oe = 1'b0;
   logic [NC*3-1:0] cfg_mode;
   logic [NC-1:0] cfg_inv  = '0;
   logic [NC-1:0] core_out = '0;
   logic [NC-1:0] core_in;
   logic [NC-1:0] pad_in   = '1;
   logic [NC-1:0] pad_out;
   logic [NC-1:0] pad_oe;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk_io = ~clk_io;

   pad_cell_group #(.NUM_CELLS(NC)) i_pad_cell_group (
      .clk_io   (clk_io),
      .rst_n    (rst_n),
      .grp_oe   (grp_oe),
      .cfg_mode (cfg_mode),
      .cfg_inv  (cfg_inv),
      .core_out (core_out),
      .core_in  (core_in),
      .pad_in   (pad_in),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   task automatic chk(input string tag, input logic [NC-1:0] got, input logic [NC-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic all_mode(input logic [2:0] m);
      for (int i = 0; i < NC; i++) cfg_mode[i*3 +: 3] = m;
   endtask

   task automatic t_reset();
      all_mode(3'b001);
      repeat (3) @(posedge clk_io);
      #3;
      chk("R7 flop cleared in reset", core_in, '0);
      all_mode(3'b010);
      #1;
      chk("R7 latch cleared in reset (clk high)", core_in, '0);
      @(negedge clk_io);
      #2 rst_n = 1'b1;
   endtask

   task automatic t_comb();
      all_mode(3'b000);
      grp_oe = 1'b1;
      pad_in = 16'hA5A5;
      #1;
      chk("R1 comb core_in", core_in, 16'hA5A5);
      chk("R1 R9 comb pad_oe low", pad_oe, '0);
      pad_in = 16'h5A3C;
      #1;
      chk("R1 comb follows", core_in, 16'h5A3C);
      grp_oe = 1'b0;
   endtask

   task automatic t_reg();
      all_mode(3'b001);
      @(negedge clk_io);
      #2 pad_in = 16'h1234;
      @(posedge clk_io);
      #2;
      chk("R2 reg capture", core_in, 16'h1234);
      #5 pad_in = 16'hFFFF;
      #1;
      chk("R2 reg holds mid-cycle", core_in, 16'h1234);
      @(posedge clk_io);
      #2;
      chk("R2 reg next capture", core_in, 16'hFFFF);
   endtask

   task automatic t_latch();
      all_mode(3'b010);
      @(posedge clk_io);
      #3 pad_in = 16'h0F0F;
      #1;
      chk("R3 latch transparent high", core_in, 16'h0F0F);
      @(negedge clk_io);
      #3 pad_in = 16'hF0F0;
      #1;
      chk("R3 latch holds low", core_in, 16'h0F0F);
      @(posedge clk_io);
      #2;
      chk("R3 latch reopens", core_in, 16'hF0F0);
   endtask

   task automatic t_out();
      all_mode(3'b011);
      grp_oe   = 1'b0;
      core_out = 16'h3C3C;
      cfg_inv  = '0;
      pad_in   = 16'h5555;
      #1;
      chk("R4 out pad_oe high", pad_oe, '1);
      chk("R4 out data", pad_out, 16'h3C3C);
      chk("R10 out readback", core_in, 16'h5555);
      cfg_inv = 16'h00FF;
      #1;
      chk("R6 polarity per cell", pad_out, 16'h3CC3);
      cfg_inv = '0;
   endtask

   task automatic t_bidir();
      all_mode(3'b100);
      grp_oe = 1'b0;
      pad_in = 16'h6789;
      core_out = 16'hAAAA;
      #1;
      chk("R5 bidir off", pad_oe, '0);
      chk("R5 bidir readback", core_in, 16'h6789);
      grp_oe = 1'b1;
      #1;
      chk("R5 R9 bidir on", pad_oe, '1);
      chk("R5 bidir data", pad_out, 16'hAAAA);
   endtask

   task automatic t_mixed();
      for (int i = 0; i < NC; i++) begin
         if (i < 4)       cfg_mode[i*3 +: 3] = 3'b000;
         else if (i < 8)  cfg_mode[i*3 +: 3] = 3'b100;
         else if (i < 12) cfg_mode[i*3 +: 3] = 3'b011;
         else             cfg_mode[i*3 +: 3] = (i == 12) ? 3'b101 : (i == 13) ? 3'b110 : 3'b111;
      end
      pad_in = 16'hC3A1;
      grp_oe = 1'b1;
      #1;
      chk("R9 mixed enable, grp on", pad_oe, 16'h0FF0);
      chk("R8 unused codes read pad", core_in, 16'hC3A1);
      grp_oe = 1'b0;
      #1;
      chk("R9 mixed enable, grp off", pad_oe, 16'h0F00);
   endtask

   task automatic t_inv_capture();
      all_mode(3'b001);
      cfg_inv = '1;
      @(negedge clk_io);
      #2 pad_in = 16'h8421;
      @(posedge clk_io);
      #2;
      chk("R6 capture not inverted", core_in, 16'h8421);
      cfg_inv = '0;
   endtask

   task automatic t_rst_mid();
      all_mode(3'b001);
      @(negedge clk_io);
      #2 rst_n = 1'b0;
      #1;
      chk("R7 async clear mid-cycle", core_in, '0);
      @(negedge clk_io);
      #2 rst_n = 1'b1;
      @(posedge clk_io);
      #2;
      chk("R7 capture after reset", core_in, 16'h8421);
   endtask

   initial begin
      all_mode(3'b001);
      t_reset();
      t_comb();
      t_reg();
      t_latch();
      t_out();
      t_bidir();
      t_mixed();
      t_inv_capture();
      t_rst_mid();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule